// File: doc/BRIEF.md
# Disk Sequencer Control and Error Status

This block holds the control bits and the error flags for a disk-format sequencer. A processor writes a control byte. That byte selects whether the read gate is stretched, which source drives the combined sector-mark/index interrupt, whether the buffer is accessed for a compare, and whether the running command is aborted. The block gathers error pulses from the checksum, parity and sync-search logic into sticky flags. It reports those flags on a status bus and raises a stop request toward the sequencer.

The read gate seen by the read channel is kept high after the field ends, until the checksum engine signals that it has finished, unless the control byte asks for the short form. An abort becomes a stop request only after it has been held for a minimum number of byte times. A parity error inside an instruction marked as fatal halts the sequencer at the end of that instruction and drops write gate. The ID-field checksum flag has its own set and clear events.

Top module: `seq_ctl_status`

## Requirements
- R1: The control byte is loaded on `cpu_wr`. Bit 0 is rg_keep_short, bit 1 is index-source select, bit 2 is sector-mark-source select, bit 3 is compare mode and bit 4 is abort; bits 7..5 are ignored. `irq_src_o` = {bit 2, bit 1} and `cmp_en_o` = bit 3, from the cycle after the write. The two select bits affect no output other than `irq_src_o`.
- R2: Reset does not change the control byte. During reset and after it, all status flags, the read-gate stretch, the abort count and the halt are zero, so `stop_req_o` is 0.
- R3: With rg_keep_short = 0, `rg_o` is high while `rg_field` is high. After `rg_field` falls, `rg_o` stays high up to and including the cycle in which `chk_done` is 1. It is low from the next cycle on.
- R4: With rg_keep_short = 1, `rg_o` equals `rg_field`.
- R5: While abort is held, each `byte_tick` is counted up to KILL_HOLD (default 2). Once the count reaches KILL_HOLD, `stop_req_o` is high on the following cycle and stays high while abort is held. It drops one cycle after abort is written to 0.
- R6: If abort is released before KILL_HOLD ticks are counted, no stop request is raised, and the count starts again from zero at the next abort.
- R7: A `chk_fault` pulse with `ignore_err` = 0 sets status bit 0 on the next cycle and raises `stop_req_o`.
- R8: While `ignore_err` = 1, status bit 0 reads 0, a `chk_fault` is not latched, and no stop request is raised for it.
- R9: An `id_retry` pulse sets status bit 1. A low-to-high change of `id_field` clears it on the next cycle, and a set in the same cycle takes priority.
- R10: `par_fault` sets status bit 2 and `sync_fault` sets status bit 3. Each flag stays set until `clr_err`, and a set in the same cycle as `clr_err` takes priority.
- R11: A `par_fault` while `fail_bit` = 1 is held pending until `instr_end`. From the next cycle on, `stop_req_o` is 1 and `wg_o` is 0 until `clr_err`. Without `fail_bit`, `wg_o` follows `wg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Control byte write strobe |
| cpu_wdata | input | 8 | Control byte |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| rg_field | input | 1 | Read gate from the sequencer |
| chk_done | input | 1 | Checksum calculation finished |
| chk_fault | input | 1 | ECC/CRC error pulse |
| ignore_err | input | 1 | Ignore checksum errors |
| id_field | input | 1 | ID field read active |
| id_retry | input | 1 | ID checksum error causing retry |
| par_fault | input | 1 | Buffer parity error pulse |
| fail_bit | input | 1 | Current instruction is marked fatal |
| instr_end | input | 1 | End of current instruction |
| sync_fault | input | 1 | Sync search failed |
| clr_err | input | 1 | Clear error flags |
| wg_in | input | 1 | Write gate from the sequencer |
| status_o | output | 4 | {sync, parity, ID, checksum} flags |
| irq_src_o | output | 2 | {sector-mark select, index select} |
| cmp_en_o | output | 1 | Compare mode |
| rg_o | output | 1 | Stretched read gate |
| wg_o | output | 1 | Gated write gate |
| stop_req_o | output | 1 | Stop request to the sequencer |

## Verification
The assertions check these relations on every cycle: read gate is never lower than the raw gate and stays up after a stretched field, the checksum flag is masked while errors are ignored, a rising ID field clears the ID flag, the sync flag is sticky, and a halt forces write gate low and stop high. Some properties depend on history: the abort hold count and its restart, the point at which the stretch ends on checksum completion, and the control byte surviving reset. Only the bench scenarios exercise these, and a cycle-accurate model compares every output against them on each clock.

// File: rtl/seqcs_pkg.sv
package seqcs_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_N  = 4;

    // status bit positions
    localparam int ERR_CHK  = 0;
    localparam int ERR_ID   = 1;
    localparam int ERR_PAR  = 2;
    localparam int ERR_SYNC = 3;

    // control byte bit positions
    localparam int B_SHORT = 0;
    localparam int B_IXSEL = 1;
    localparam int B_SMSEL = 2;
    localparam int B_CMP   = 3;
    localparam int B_ABORT = 4;

    typedef struct packed {
        logic abort;
        logic cmp_mode;
        logic sm_sel;
        logic ix_sel;
        logic keep_short;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [DATA_W-1:0] d);
        ctl_t c;
        c.keep_short = d[B_SHORT];
        c.ix_sel     = d[B_IXSEL];
        c.sm_sel     = d[B_SMSEL];
        c.cmp_mode   = d[B_CMP];
        c.abort      = d[B_ABORT];
        return c;
    endfunction

endpackage

// File: rtl/seqcs_flag.sv
module seqcs_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/seqcs_kill.sv
module seqcs_kill #(
    parameter int KILL_HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick,
    output logic fired
);
    localparam int CW = $clog2(KILL_HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(KILL_HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (!hold)                 cnt_q <= '0;
        else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign fired = (cnt_q == LIMIT);
endmodule

// File: rtl/seqcs_rg_ext.sv
module seqcs_rg_ext (
    input  logic clk,
    input  logic rst,
    input  logic rg_in,
    input  logic keep_short,
    input  logic done,
    output logic rg_out
);
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst)                       ext_q <= 1'b0;
        else if (rg_in && !keep_short) ext_q <= 1'b1;
        else if (keep_short || done)   ext_q <= 1'b0;
    end

    assign rg_out = rg_in | ext_q;
endmodule

// File: rtl/seq_ctl_status.sv
module seq_ctl_status
    import seqcs_pkg::*;
#(
    parameter int KILL_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              byte_tick,
    input  logic              rg_field,
    input  logic              chk_done,
    input  logic              chk_fault,
    input  logic              ignore_err,
    input  logic              id_field,
    input  logic              id_retry,
    input  logic              par_fault,
    input  logic              fail_bit,
    input  logic              instr_end,
    input  logic              sync_fault,
    input  logic              clr_err,
    input  logic              wg_in,
    output logic [ERR_N-1:0]  status_o,
    output logic [1:0]        irq_src_o,
    output logic              cmp_en_o,
    output logic              rg_o,
    output logic              wg_o,
    output logic              stop_req_o
);
    // control byte: deliberately without reset
    ctl_t ctl_q;
    always_ff @(posedge clk) begin
        if (cpu_wr) ctl_q <= decode_ctl(cpu_wdata);
    end

    logic rg_short;
    assign rg_short  = ctl_q.keep_short;
    assign irq_src_o = {ctl_q.sm_sel, ctl_q.ix_sel};
    assign cmp_en_o  = ctl_q.cmp_mode;

    seqcs_rg_ext u_rg (
        .clk       (clk),
        .rst       (rst),
        .rg_in     (rg_field),
        .keep_short(rg_short),
        .done      (chk_done),
        .rg_out    (rg_o)
    );

    logic kill_fired;
    seqcs_kill #(.KILL_HOLD(KILL_HOLD)) u_kill (
        .clk  (clk),
        .rst  (rst),
        .hold (ctl_q.abort),
        .tick (byte_tick),
        .fired(kill_fired)
    );

    // ID field edge detect
    logic id_prev_q, id_rise;
    always_ff @(posedge clk) begin
        if (rst) id_prev_q <= 1'b0;
        else     id_prev_q <= id_field;
    end
    assign id_rise = id_field & ~id_prev_q;

    // sticky error flags
    logic [ERR_N-1:0] flg_set, flg_clr, flg_q;
    always_comb begin
        flg_set           = '0;
        flg_set[ERR_CHK]  = chk_fault & ~ignore_err;
        flg_set[ERR_ID]   = id_retry;
        flg_set[ERR_PAR]  = par_fault;
        flg_set[ERR_SYNC] = sync_fault;
        flg_clr           = {ERR_N{clr_err}};
        flg_clr[ERR_ID]   = clr_err | id_rise;
    end

    for (genvar g = 0; g < ERR_N; g++) begin : g_flag
        seqcs_flag u_flag (
            .clk(clk),
            .rst(rst),
            .set(flg_set[g]),
            .clr(flg_clr[g]),
            .q  (flg_q[g])
        );
    end

    logic [ERR_N-1:0] rd_mask;
    always_comb begin
        rd_mask          = '1;
        rd_mask[ERR_CHK] = ~ignore_err;
    end
    assign status_o = flg_q & rd_mask;

    // fatal parity: pending until the instruction ends, then halt
    logic par_fatal, pend_q, halt_q, halt_set;
    assign par_fatal = par_fault & fail_bit;
    assign halt_set  = instr_end & (pend_q | par_fatal);

    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (instr_end) pend_q <= 1'b0;
        else if (par_fatal) pend_q <= 1'b1;
        else if (clr_err)   pend_q <= 1'b0;
    end

    seqcs_flag u_halt (
        .clk(clk),
        .rst(rst),
        .set(halt_set),
        .clr(clr_err),
        .q  (halt_q)
    );

    assign wg_o       = wg_in & ~halt_q;
    assign stop_req_o = kill_fired | halt_q | status_o[ERR_CHK];
endmodule

// File: rtl/seqcs_chk.sv
module seqcs_chk (
    input logic       clk,
    input logic       rst,
    input logic       rg_field,
    input logic       rg_short,
    input logic       rg_o,
    input logic       ignore_err,
    input logic [3:0] status_o,
    input logic       id_field,
    input logic       id_retry,
    input logic       clr_err,
    input logic       wg_in,
    input logic       wg_o,
    input logic       halt_q,
    input logic       stop_req_o
);
    // R3
    rg_cover_chk: assert property (@(posedge clk) disable iff (rst)
        rg_field |-> rg_o);

    // R3
    rg_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rg_field) && !$past(rg_short)) |-> rg_o);

    // R8
    ignore_mask_chk: assert property (@(posedge clk) disable iff (rst)
        ignore_err |-> !status_o[0]);

    // R9
    id_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (id_field && !$past(id_field) && !id_retry) |=> !status_o[1]);

    // R10
    sync_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o[3] && !clr_err) |=> status_o[3]);

    // R11
    wg_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wg_o |-> wg_in);

    // R11
    halt_effect_chk: assert property (@(posedge clk) disable iff (rst)
        halt_q |-> (!wg_o && stop_req_o));
endmodule

bind seq_ctl_status seqcs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rg_field  (rg_field),
    .rg_short  (rg_short),
    .rg_o      (rg_o),
    .ignore_err(ignore_err),
    .status_o  (status_o),
    .id_field  (id_field),
    .id_retry  (id_retry),
    .clr_err   (clr_err),
    .wg_in     (wg_in),
    .wg_o      (wg_o),
    .halt_q    (halt_q),
    .stop_req_o(stop_req_o)
);

// File: tb/sim_seq_ctl_status.sv
module sim_seq_ctl_status;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, cpu_wr = 1'b0, byte_tick = 1'b0, rg_field = 1'b0;
    logic chk_done = 1'b0, chk_fault = 1'b0, ignore_err = 1'b0, id_field = 1'b0;
    logic id_retry = 1'b0, par_fault = 1'b0, fail_bit = 1'b0, instr_end = 1'b0;
    logic sync_fault = 1'b0, clr_err = 1'b0, wg_in = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [3:0] status_o;
    logic [1:0] irq_src_o;
    logic cmp_en_o, rg_o, wg_o, stop_req_o;

    seq_ctl_status #(.KILL_HOLD(HOLD)) u0 (.*);

    int vectors = 0, miscompares = 0;
    string cur_req = "R2";

    // reference model state
    bit m_short, m_ix, m_sm, m_cmp, m_abort;
    int m_kcnt;
    bit m_ext, m_chk, m_id, m_par, m_sync, m_pend, m_halt, m_idprev;

    task automatic model_update();
        bit pf, rise;
        pf   = par_fault && fail_bit;
        rise = id_field && !m_idprev;
        if (rst) begin
            m_kcnt = 0; m_ext = 0; m_chk = 0; m_id = 0; m_par = 0;
            m_sync = 0; m_pend = 0; m_halt = 0; m_idprev = 0;
        end else begin
            if (!m_abort) m_kcnt = 0;
            else if (byte_tick && m_kcnt < HOLD) m_kcnt++;
            if (rg_field && !m_short) m_ext = 1;
            else if (m_short || chk_done) m_ext = 0;
            if (chk_fault && !ignore_err) m_chk = 1; else if (clr_err) m_chk = 0;
            if (id_retry) m_id = 1; else if (clr_err || rise) m_id = 0;
            if (par_fault) m_par = 1; else if (clr_err) m_par = 0;
            if (sync_fault) m_sync = 1; else if (clr_err) m_sync = 0;
            if (instr_end && (m_pend || pf)) m_halt = 1; else if (clr_err) m_halt = 0;
            if (instr_end) m_pend = 0; else if (pf) m_pend = 1; else if (clr_err) m_pend = 0;
            m_idprev = id_field;
        end
        if (cpu_wr) begin
            m_short = cpu_wdata[0]; m_ix = cpu_wdata[1]; m_sm = cpu_wdata[2];
            m_cmp = cpu_wdata[3]; m_abort = cpu_wdata[4];
        end
    endtask

    task automatic chk1(string name, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk1("status_o", status_o, {m_sync, m_par, m_id, m_chk && !ignore_err});
        chk1("irq_src_o", {2'b0, irq_src_o}, {2'b0, m_sm, m_ix});
        chk1("cmp_en_o", {3'b0, cmp_en_o}, {3'b0, m_cmp});
        chk1("rg_o", {3'b0, rg_o}, {3'b0, rg_field || m_ext});
        chk1("wg_o", {3'b0, wg_o}, {3'b0, wg_in && !m_halt});
        chk1("stop_req_o", {3'b0, stop_req_o},
             {3'b0, (m_kcnt == HOLD) || m_halt || (m_chk && !ignore_err)});
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_update();
            #1;
            compare();
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [7:0] d);
        cpu_wr = 1'b1; cpu_wdata = d; cyc(); cpu_wr = 1'b0; cyc();
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; cyc(); s = 1'b0; cyc(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R2: control written during reset, flags cleared by reset
        cur_req = "R2";
        cpu_wr = 1'b1; cpu_wdata = 8'h00; cyc();
        cpu_wr = 1'b0; cyc(2);
        rst = 1'b0; cyc(2);
        wr(8'h0E);
        sync_fault = 1'b1; cyc(); sync_fault = 1'b0; cyc();
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);   // R2 control kept, flags gone

        // R1: field placement and ignored high bits
        cur_req = "R1";
        wr(8'h02); wr(8'h04); wr(8'h08); wr(8'hE0); wr(8'h06);
        wg_in = 1'b1; rg_field = 1'b1; cyc(2); rg_field = 1'b0; cyc(2);
        wr(8'h00);

        // R3: stretch until checksum done
        cur_req = "R3";
        rg_field = 1'b1; cyc(3); rg_field = 1'b0; cyc(3);
        chk_done = 1'b1; cyc(); chk_done = 1'b0; cyc(2);
        rg_field = 1'b1; chk_done = 1'b1; cyc(); chk_done = 1'b0; cyc();
        rg_field = 1'b0; chk_done = 1'b1; cyc(); chk_done = 1'b0; cyc(2);

        // R4: short form
        cur_req = "R4";
        wr(8'h01);
        rg_field = 1'b1; cyc(3); rg_field = 1'b0; cyc(3);
        chk_done = 1'b1; cyc(); chk_done = 1'b0; cyc();

        // R5: abort held long enough
        cur_req = "R5";
        wr(8'h10);
        for (int k = 0; k < 4; k++) begin
            byte_tick = 1'b1; cyc(); byte_tick = 1'b0; cyc(3);
        end
        wr(8'h00); cyc(2);

        // R6: abort released too early, then count restarts
        cur_req = "R6";
        wr(8'h10);
        byte_tick = 1'b1; cyc(); byte_tick = 1'b0; cyc(2);
        wr(8'h00); cyc();
        wr(8'h10);
        byte_tick = 1'b1; cyc(); byte_tick = 1'b0; cyc(3);
        wr(8'h00); cyc(2);

        // R7: checksum error latches and stops
        cur_req = "R7";
        pulse(chk_fault); cyc(2);
        pulse(clr_err);

        // R8: ignore masks, does not latch
        cur_req = "R8";
        ignore_err = 1'b1; pulse(chk_fault); ignore_err = 1'b0; cyc(2);
        pulse(chk_fault); ignore_err = 1'b1; cyc(2); ignore_err = 1'b0; cyc();
        pulse(clr_err);

        // R9: ID flag set/clear
        cur_req = "R9";
        pulse(id_retry);
        id_field = 1'b1; cyc(2);
        pulse(id_retry);
        id_field = 1'b0; cyc(); id_field = 1'b1; id_retry = 1'b1; cyc();
        id_retry = 1'b0; cyc(2);
        id_field = 1'b0; cyc(); id_field = 1'b1; cyc(2); id_field = 1'b0; cyc();

        // R10: sticky parity and sync flags
        cur_req = "R10";
        pulse(par_fault); pulse(sync_fault); cyc(2);
        clr_err = 1'b1; sync_fault = 1'b1; cyc();
        clr_err = 1'b0; sync_fault = 1'b0; cyc(2);
        pulse(clr_err);

        // R11: fatal parity halts at instruction end
        cur_req = "R11";
        wg_in = 1'b1; fail_bit = 1'b1;
        pulse(par_fault); cyc(2);
        pulse(instr_end); cyc(3);
        pulse(clr_err);
        par_fault = 1'b1; instr_end = 1'b1; cyc();
        par_fault = 1'b0; instr_end = 1'b0; cyc(2);
        pulse(clr_err);
        fail_bit = 1'b0;
        pulse(par_fault); pulse(instr_end); cyc(2);
        pulse(clr_err);
        wg_in = 1'b0; cyc(2);

        finish_run();
    end
endmodule